// File: doc/BRIEF.md
# Adjacent-Pair Instruction Fusion Detector

This block sits between an instruction fetch buffer and the decoder of a 32-bit RISC-V pipeline. Each cycle it looks at a window of two neighbouring instruction words. When they form one of two known fusible shapes, it emits a single fused micro-op that describes both. Otherwise it issues the first word alone. It also tells the fetch buffer whether to advance by one word or by two.

The first shape is a carry sequence. An unsigned set-less-than writes a register. The very next instruction is an add that reads that register and overwrites it. Together they become a three-source add: rd = (rs1 <u rs2) + rs3. The second shape is a conditional branch whose target is exactly one 32-bit instruction ahead. It is fused with the plain ALU instruction it would skip, and that instruction becomes predicated: its write is suppressed when the branch condition holds. In both shapes the pair changes exactly one architectural register.

The result is held in an output register with a valid/ready handshake. While the decoder stalls, the held micro-op stays unchanged. The detector also takes nothing from the window, so the fetch buffer keeps it as it is.

Top module: `fuse_pair_detector`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_take` is 0 while nothing is accepted.
- R2: Carry fusion applies when word0 is SLTU and word1 is ADD. SLTU means opcode 0110011, funct3 011, funct7 0. ADD means opcode 0110011, funct3 000, funct7 0. Word1's rd (bits 11:7) must equal word0's rd, and word1 must read that register in exactly one source field. The result is `out_fused`=1, `out_kind`=01, `out_rd`=rd, `out_consumed`=2, `out_word0`/`out_word1` = the two words.
- R3: For a carry fusion, `out_rs3` is the ADD source field (rs1 bits 19:15 or rs2 bits 24:20) that does not equal rd. If both ADD sources equal rd, there is no fusion.
- R4: A carry pair whose SLTU destination is x0 is not fused.
- R5: A carry pair whose ADD writes a register other than the SLTU destination, or whose ADD does not read that destination, is not fused.
- R6: Branch fusion applies when word0 is a conditional branch with a +8 offset and word1 is a plain ALU op with rd ≠ x0. A conditional branch is opcode 1100011 with funct3 not 010 or 011. A +8 offset means bits 31:25 = 0 and bits 11:7 = 01000. A plain ALU op is opcode 0010011, or opcode 0110011 with funct7 0000000 or 0100000. The result is `out_fused`=1, `out_kind`=10, `out_rd` = word1's rd, `out_rs3`=0, `out_consumed`=2.
- R7: Branches with a backward offset, or with any forward offset other than +8, are never fused.
- R8: A +8 branch is not fused when the skipped word is a load, store, branch, jump, system or multiply/divide (funct7 0000001) instruction, or when it writes x0.
- R9: When `in_valid1` is 0, no fusion happens and `out_consumed` is 1.
- R10: An unfused issue gives `out_word0` = word0, `out_word1`=0, `out_fused`=0, `out_kind`=00, `out_rd`=0, `out_rs3`=0, `out_consumed`=1.
- R11: `in_ready` = !`out_valid` | `out_ready`. While `out_valid` is 1 and `out_ready` is 0, all outputs hold and `in_take` is 0.
- R12: `in_take` is 0 unless `in_valid0` and `in_ready` are both 1. When they are, `in_take` equals the `out_consumed` value that the next clock edge registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid0 | input | 1 | First window word present |
| in_word0 | input | 32 | First (older) instruction word |
| in_valid1 | input | 1 | Second window word present |
| in_word1 | input | 32 | Second instruction word |
| in_ready | output | 1 | Window accepted at this edge if valid |
| in_take | output | 2 | Words the fetch buffer drops at this edge (0, 1 or 2) |
| out_valid | output | 1 | Micro-op held for the decoder |
| out_ready | input | 1 | Decoder accepts the micro-op |
| out_word0 | output | 32 | First instruction of the micro-op |
| out_word1 | output | 32 | Second instruction when fused, else 0 |
| out_fused | output | 1 | Micro-op covers two instructions |
| out_kind | output | 2 | 00 none, 01 carry add, 10 predicated |
| out_rd | output | 5 | Single destination of a fused op |
| out_rs3 | output | 5 | Third source of a carry op |
| out_consumed | output | 2 | Words covered by this micro-op |

## Verification
The stimulus targets carry pairs where the ADD reads rd in the first source field, in the second, in both, and in neither. A detector that picked the wrong field would name rd as the third source, so the fused add would read a stale value. Writes to x0 and mismatched destinations are included; fusing these would drop an architectural write that the ADD depends on. Branches at +8, -8, +4 and +12 are mixed with skipped loads, multiplies and branches, since predicating any of those would hide a side effect. The second-word valid flag is dropped on some fusible pairs, and the decoder stalls at random. A detector that advanced the window during a stall, or fused across a missing word, would lose or repeat instructions in the issued stream.

// File: rtl/fuse_pair_detector.sv
module fuse_pair_detector #(
  parameter int IW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid0,
  input  logic [IW-1:0] in_word0,
  input  logic          in_valid1,
  input  logic [IW-1:0] in_word1,
  output logic          in_ready,
  output logic [1:0]    in_take,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [IW-1:0] out_word0,
  output logic [IW-1:0] out_word1,
  output logic          out_fused,
  output logic [1:0]    out_kind,
  output logic [RW-1:0] out_rd,
  output logic [RW-1:0] out_rs3,
  output logic [1:0]    out_consumed
);
  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [6:0] OPC_IMM = 7'b0010011;
  localparam logic [6:0] OPC_BR  = 7'b1100011;
  localparam logic [1:0] K_NONE  = 2'b00;
  localparam logic [1:0] K_CARRY = 2'b01;
  localparam logic [1:0] K_PRED  = 2'b10;

  logic [6:0]    op0, op1, f7_0, f7_1;
  logic [2:0]    f3_0, f3_1;
  logic [RW-1:0] dst0, dst1, src1a, src1b;

  assign op0   = in_word0[6:0];
  assign op1   = in_word1[6:0];
  assign f3_0  = in_word0[14:12];
  assign f3_1  = in_word1[14:12];
  assign f7_0  = in_word0[31:25];
  assign f7_1  = in_word1[31:25];
  assign dst0  = in_word0[11:7];
  assign dst1  = in_word1[11:7];
  assign src1a = in_word1[19:15];
  assign src1b = in_word1[24:20];

  logic is_sltu0, is_add1, hit_a, hit_b, carry_ok;
  assign is_sltu0 = (op0 == OPC_REG) && (f3_0 == 3'b011) && (f7_0 == 7'd0);
  assign is_add1  = (op1 == OPC_REG) && (f3_1 == 3'b000) && (f7_1 == 7'd0);
  assign hit_a    = (src1a == dst0);
  assign hit_b    = (src1b == dst0);
  assign carry_ok = in_valid1 && is_sltu0 && is_add1 && (dst0 != '0)
                    && (dst1 == dst0) && (hit_a ^ hit_b);

  logic is_br0, fwd_one, alu1, pred_ok;
  assign is_br0  = (op0 == OPC_BR) && (f3_0[2:1] != 2'b01);
  assign fwd_one = (f7_0 == 7'd0) && (in_word0[11:7] == 5'b01000);
  assign alu1    = ((op1 == OPC_IMM) ||
                    ((op1 == OPC_REG) && ((f7_1 == 7'h00) || (f7_1 == 7'h20))))
                   && (dst1 != '0);
  assign pred_ok = in_valid1 && is_br0 && fwd_one && alu1;

  logic fuse, accept;
  assign fuse     = carry_ok || pred_ok;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid0 && in_ready;
  assign in_take  = accept ? (fuse ? 2'd2 : 2'd1) : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_word0    <= '0;
      out_word1    <= '0;
      out_fused    <= 1'b0;
      out_kind     <= K_NONE;
      out_rd       <= '0;
      out_rs3      <= '0;
      out_consumed <= 2'd0;
    end else if (in_ready) begin
      out_valid <= in_valid0;
      if (in_valid0) begin
        out_word0    <= in_word0;
        out_word1    <= fuse ? in_word1 : '0;
        out_fused    <= fuse;
        out_kind     <= carry_ok ? K_CARRY : (pred_ok ? K_PRED : K_NONE);
        out_rd       <= fuse ? dst1 : '0;
        out_rs3      <= carry_ok ? (hit_a ? src1b : src1a) : '0;
        out_consumed <= fuse ? 2'd2 : 2'd1;
      end
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word0) && $stable(out_word1)
      && $stable(out_kind) && $stable(out_rs3) && $stable(out_consumed)));

  assert_take_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_take != 2'd0) |=> (out_valid && (out_consumed == $past(in_take))));

  assert_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fused == (out_consumed == 2'd2)));

  assert_rs3_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == K_CARRY) |-> (out_rs3 != out_rd));

  assert_x0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fused) |-> (out_rd != '0));
endmodule

// File: tb/fuse_pair_detector_tb.sv
module fuse_pair_detector_tb_top;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic in_valid0 = 0, in_valid1 = 0, out_ready = 0;
  logic [31:0] in_word0 = 0, in_word1 = 0;
  logic in_ready, out_valid, out_fused;
  logic [1:0] in_take, out_kind, out_consumed;
  logic [31:0] out_word0, out_word1;
  logic [4:0] out_rd, out_rs3;

  fuse_pair_detector dut_i (.*);

  int errors = 0, checks = 0;

  typedef struct packed {
    logic [31:0] w0; logic [31:0] w1; logic [1:0] kind;
    logic [4:0] rd; logic [4:0] rs3; logic [1:0] cnt;
  } exp_t;

  exp_t expq[$];
  string tagq[$];
  logic [31:0] prog[$];
  bit cut[$];
  int p = 0;

  function automatic logic [31:0] rr(logic [6:0] f7, logic [4:0] b, logic [4:0] a,
                                     logic [2:0] f3, logic [4:0] d, logic [6:0] op);
    return {f7, b, a, f3, d, op};
  endfunction
  function automatic logic [31:0] sltu(logic [4:0] d, logic [4:0] a, logic [4:0] b);
    return rr(7'h00, b, a, 3'b011, d, 7'h33);
  endfunction
  function automatic logic [31:0] add(logic [4:0] d, logic [4:0] a, logic [4:0] b);
    return rr(7'h00, b, a, 3'b000, d, 7'h33);
  endfunction
  function automatic logic [31:0] mul(logic [4:0] d, logic [4:0] a, logic [4:0] b);
    return rr(7'h01, b, a, 3'b000, d, 7'h33);
  endfunction
  function automatic logic [31:0] addi(logic [4:0] d, logic [4:0] a, logic [11:0] im);
    return {im, a, 3'b000, d, 7'h13};
  endfunction
  function automatic logic [31:0] lw(logic [4:0] d, logic [4:0] a);
    return {12'd4, a, 3'b010, d, 7'h03};
  endfunction
  function automatic logic [31:0] br(logic [2:0] f3, logic [4:0] a, logic [4:0] b, int off);
    logic [12:0] o;
    o = off[12:0];
    return {o[12], o[10:5], b, a, f3, o[4:1], o[11], 7'h63};
  endfunction

  // Behavioural oracle built from the requirement text.
  function automatic void model(input logic [31:0] w0, input bit v1, input logic [31:0] w1,
                                output exp_t e, output string tag);
    bit s0, a1, b0, plain;
    int off;
    e = '{w0: w0, w1: 0, kind: 0, rd: 0, rs3: 0, cnt: 1};
    tag = "R10";
    s0 = w0[6:0] == 7'h33 && w0[14:12] == 3 && w0[31:25] == 0;
    a1 = w1[6:0] == 7'h33 && w1[14:12] == 0 && w1[31:25] == 0;
    b0 = w0[6:0] == 7'h63 && w0[14:12] != 2 && w0[14:12] != 3;
    off = $signed({w0[31], w0[7], w0[30:25], w0[11:8], 1'b0});
    plain = (w1[6:0] == 7'h13 || (w1[6:0] == 7'h33 && (w1[31:25] == 0 || w1[31:25] == 7'h20)))
            && w1[11:7] != 0;
    if (!v1) begin
      if (s0 || b0) tag = "R9";
    end else if (s0 && a1) begin
      if (w0[11:7] == 0) tag = "R4";
      else if (w1[11:7] != w0[11:7]) tag = "R5";
      else if (w1[19:15] == w0[11:7] && w1[24:20] == w0[11:7]) tag = "R3";
      else if (w1[19:15] != w0[11:7] && w1[24:20] != w0[11:7]) tag = "R5";
      else begin
        e.kind = 1; e.cnt = 2; e.w1 = w1; e.rd = w0[11:7];
        e.rs3 = (w1[19:15] == w0[11:7]) ? w1[24:20] : w1[19:15];
        tag = (w1[24:20] == w0[11:7]) ? "R3" : "R2";
      end
    end else if (b0) begin
      if (off != 8) tag = "R7";
      else if (!plain) tag = "R8";
      else begin
        e.kind = 2; e.cnt = 2; e.w1 = w1; e.rd = w1[11:7]; tag = "R6";
      end
    end
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic put(logic [31:0] w, bit c = 0);
    prog.push_back(w); cut.push_back(c);
  endtask

  bit stalled = 0;
  logic [31:0] h_w0;
  logic [1:0] h_kind, h_cnt;

  task automatic drive(bit rnd_ready);
    out_ready = rnd_ready ? ($urandom % 4 != 0) : 1'b1;
    in_valid0 = p < prog.size();
    in_word0  = in_valid0 ? prog[p] : 32'h0;
    in_valid1 = (p + 1 < prog.size()) && !cut[p];
    in_word1  = in_valid1 ? prog[p+1] : 32'h0;
  endtask

  task automatic sample();
    exp_t e, got;
    string tag;
    logic [1:0] et;
    model(in_word0, in_valid1, in_word1, e, tag);
    if (stalled) begin
      chk(out_valid && out_word0 == h_w0 && out_kind == h_kind && out_consumed == h_cnt,
          "R11", "held output", {out_valid, out_kind, out_consumed}, {1'b1, h_kind, h_cnt});
    end
    chk(in_ready == (!out_valid || out_ready), "R11", "in_ready", in_ready, !out_valid || out_ready);
    et = (in_valid0 && in_ready) ? e.cnt : 2'd0;
    chk(in_take == et, (et == 0) ? "R11" : "R12", "in_take", in_take, et);
    if (out_valid && out_ready) begin
      got = '{w0: out_word0, w1: out_word1, kind: out_kind, rd: out_rd, rs3: out_rs3,
              cnt: out_consumed};
      if (expq.size() == 0) chk(0, "R12", "unexpected output", got.w0, 0);
      else begin
        chk(got == expq[0] && out_fused == (expq[0].kind != 0), tagq[0], "micro-op",
            got, expq[0]);
        void'(expq.pop_front()); void'(tagq.pop_front());
      end
    end
    stalled = out_valid && !out_ready;
    h_w0 = out_word0; h_kind = out_kind; h_cnt = out_consumed;
    if (et != 0) begin
      expq.push_back(e); tagq.push_back(tag); p += e.cnt;
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R2 / R3: rd in either ADD source, and in both
    put(sltu(5, 1, 2)); put(add(5, 5, 3));
    put(sltu(6, 1, 2)); put(add(6, 4, 6));
    put(sltu(7, 1, 2)); put(add(7, 7, 7));
    // R4, R5
    put(sltu(0, 1, 2)); put(add(0, 0, 3));
    put(sltu(8, 1, 2)); put(add(9, 8, 3));
    put(sltu(8, 1, 2)); put(add(8, 2, 3));
    // R9: fusible pair with second word withheld
    put(sltu(10, 1, 2), 1); put(add(10, 10, 3));
    put(br(3'b000, 1, 2, 8), 1); put(addi(4, 4, 12'd1));
    // R6
    put(br(3'b001, 1, 2, 8)); put(addi(4, 4, 12'd1));
    put(br(3'b111, 3, 2, 8)); put(rr(7'h20, 2, 3, 3'b000, 9, 7'h33));
    // R7
    put(br(3'b000, 1, 2, -8)); put(addi(4, 4, 12'd1));
    put(br(3'b100, 1, 2, 12)); put(addi(4, 4, 12'd1));
    put(br(3'b101, 1, 2, 4)); put(addi(4, 4, 12'd1));
    // R8
    put(br(3'b000, 1, 2, 8)); put(lw(4, 2));
    put(br(3'b000, 1, 2, 8)); put(mul(4, 2, 3));
    put(br(3'b000, 1, 2, 8)); put(br(3'b000, 1, 2, 8));
    put(br(3'b110, 1, 2, 8)); put(addi(0, 4, 12'd1));
    put(addi(3, 3, 12'd5));

    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(out_valid == 0 && in_take == 0, "R1", "reset state", {out_valid, in_take}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1", "idle after reset", out_valid, 0);
    for (int ph = 0; ph < 2; ph++) begin
      if (ph == 1) begin
        for (int i = 0; i < 400; i++) begin
          logic [4:0] a, b, d;
          a = 5'($urandom % 4); b = 5'($urandom % 4); d = 5'($urandom % 4);
          case ($urandom % 7)
            0, 1: put(sltu(d, a, b));
            2, 3: put(add(d, a, b));
            4: put(br(3'($urandom % 8), a, b, ($urandom % 3 == 0) ? -8 : (($urandom % 2) ? 8 : 12)));
            5: put(addi(d, a, 12'd3));
            default: put(($urandom % 2) ? lw(d, a) : mul(d, a, b));
          endcase
          cut[cut.size()-1] = ($urandom % 8 == 0);
        end
      end
      while (p < prog.size() || expq.size() != 0 || out_valid) begin
        @(posedge clk); #1;
        drive(ph == 1);
        @(negedge clk);
        sample();
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule